// File: doc/BRIEF.md
# Capability List Walker

This block searches the classic capability chain of a configuration-space function for one capability ID. A single start strobe carries the wanted ID. The walker then reads configuration space one byte at a time through a simple request/valid port. Its first read is the header byte that holds the head pointer. It then visits each entry, reading the entry's ID byte and, when the ID does not match, the byte that follows it, which holds the link to the next entry.

The walk ends in one of three ways. A matching ID ends it with found and the entry's address. A zero link ends it with found low. A broken chain ends it with an error flag. A chain is broken if a link points under the capability region, or if the chain runs for more entries than the hop limit, which is what a circular list does. The extended capability space is never touched. Entry bodies are not interpreted.

Top module: `cap_walker`

## Requirements
- R1: After reset, busy_o, done_o, found_o, err_o and rd_req_o are all low, and offset_o is 00h.
- R2: A start_i pulse taken while idle sets busy_o, and in the next cycle the walker issues its first read, at address 34h (the head pointer byte).
- R3: Before any pointer is used as an address, its two least significant bits are treated as zero. A reported offset therefore always has bits [1:0] equal to 00.
- R4: For an entry at pointer P, the ID is read at P. If the ID differs from target_id_i, the link is then read at P+1. No other addresses are read.
- R5: When the ID read at P equals the target, the walker makes no further reads. done_o and found_o are then high for one cycle, err_o stays low and offset_o equals P.
- R6: A pointer of 00h (after the masking of R3) ends the walk with done_o high, found_o low, err_o low and offset_o 00h.
- R7: A non-zero pointer below 40h ends the walk with done_o and err_o high and found_o low. No read is issued at that pointer.
- R8: At most 48 entries are visited. A chain of exactly 48 entries completes normally. A 49th non-zero pointer ends the walk with err_o high and found_o low, so circular lists terminate.
- R9: Only one read is outstanding at a time. The walker holds in its wait state until rd_valid_i arrives, whatever the latency.
- R10: start_i is ignored while busy_o is high. It alters neither the sequence of reads nor the result.
- R11: done_o is high for exactly one cycle, with busy_o still high in that cycle. busy_o falls in the following cycle. found_o and err_o are never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (ignored while busy) |
| target_id_i | input | 8 | Capability ID to find, sampled with start_i |
| rd_req_o | output | 1 | One-cycle byte read request |
| rd_addr_o | output | 8 | Byte address of the request |
| rd_data_i | input | 8 | Returned byte, valid with rd_valid_i |
| rd_valid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | With done_o: target located |
| err_o | output | 1 | With done_o: malformed list |
| offset_o | output | 8 | Address of the matching entry (00h when not found) |

## Verification
The bench sets up lists whose links carry stray low bits, whose links drop below 40h mid-chain, and whose head pointer is zero. It also builds a self-referencing entry and a full 48-entry chain with the target in the last slot. A walker without masking would read unaligned addresses. One without the range guard would read header bytes as capability entries. An off-by-one in the hop limit would either reject the full chain or read a 49th entry. One that ignores the hop limit would loop until the watchdog fires. The bench varies read latency and fires a second start with another ID mid-walk, so a walker that advances without valid, or that takes the new ID, gives the wrong read sequence or the wrong result.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_REQ_HDR,
    S_WAIT_HDR,
    S_EVAL,
    S_REQ_ID,
    S_WAIT_ID,
    S_REQ_NXT,
    S_WAIT_NXT,
    S_DONE
  } walk_state_e;
endpackage

// File: rtl/cw_ptr_filter.sv
// Clears the alignment bits of a raw link byte and classifies it.
module cw_ptr_filter #(
  parameter int PTR_W      = 8,
  parameter int ALIGN_BITS = 2,
  parameter logic [PTR_W-1:0] CAP_BASE = 8'h40
) (
  input  logic [PTR_W-1:0] raw_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             is_null_o,
  output logic             is_low_o
);
  localparam logic [PTR_W-1:0] MASK = {{(PTR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  always_comb begin
    ptr_o     = raw_i & MASK;
    is_null_o = (ptr_o == '0);
    is_low_o  = !is_null_o && (ptr_o < CAP_BASE);
  end
endmodule

// File: rtl/cw_hop_counter.sv
// Counts visited entries and flags when the limit has been reached.
module cw_hop_counter #(
  parameter int MAX_HOPS = 48,
  localparam int HW = $clog2(MAX_HOPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  logic [HW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_n  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign at_limit_o = (cnt_q == HW'(MAX_HOPS));
endmodule

// File: rtl/cap_walker.sv
module cap_walker
  import cw_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int ID_W       = 8,
  parameter int MAX_HOPS   = 48,
  parameter int ALIGN_BITS = 2,
  parameter logic [PTR_W-1:0] HDR_OFS  = 8'h34,
  parameter logic [PTR_W-1:0] CAP_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ID_W-1:0]  target_id_i,
  output logic             rd_req_o,
  output logic [PTR_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  input  logic             rd_valid_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             found_o,
  output logic             err_o,
  output logic [PTR_W-1:0] offset_o
);
  walk_state_e      state_q, state_n;
  logic [ID_W-1:0]  tgt_q, tgt_n;
  logic [PTR_W-1:0] raw_q, raw_n;
  logic [PTR_W-1:0] off_q, off_n;
  logic             found_q, found_n;
  logic             err_q, err_n;
  logic             hop_clr, hop_inc, hop_lim;
  logic [PTR_W-1:0] cur_ptr;
  logic             ptr_null, ptr_low;

  cw_ptr_filter #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS), .CAP_BASE(CAP_BASE)) u_filt (
    .raw_i(raw_q), .ptr_o(cur_ptr), .is_null_o(ptr_null), .is_low_o(ptr_low)
  );

  cw_hop_counter #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst_n(rst_n), .clr_i(hop_clr), .inc_i(hop_inc), .at_limit_o(hop_lim)
  );

  always_comb begin
    state_n   = state_q;
    tgt_n     = tgt_q;
    raw_n     = raw_q;
    off_n     = off_q;
    found_n   = found_q;
    err_n     = err_q;
    hop_clr   = 1'b0;
    hop_inc   = 1'b0;
    rd_req_o  = 1'b0;
    rd_addr_o = HDR_OFS;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        tgt_n   = target_id_i;
        off_n   = '0;
        found_n = 1'b0;
        err_n   = 1'b0;
        hop_clr = 1'b1;
        state_n = S_REQ_HDR;
      end
      S_REQ_HDR: begin
        rd_req_o = 1'b1;
        state_n  = S_WAIT_HDR;
      end
      S_WAIT_HDR, S_WAIT_NXT: if (rd_valid_i) begin
        raw_n   = rd_data_i;
        state_n = S_EVAL;
      end
      S_EVAL: begin
        if (ptr_null) begin
          state_n = S_DONE;
        end else if (ptr_low || hop_lim) begin
          err_n   = 1'b1;
          state_n = S_DONE;
        end else begin
          hop_inc = 1'b1;
          state_n = S_REQ_ID;
        end
      end
      S_REQ_ID: begin
        rd_req_o  = 1'b1;
        rd_addr_o = cur_ptr;
        state_n   = S_WAIT_ID;
      end
      S_WAIT_ID: if (rd_valid_i) begin
        if (rd_data_i[ID_W-1:0] == tgt_q) begin
          found_n = 1'b1;
          off_n   = cur_ptr;
          state_n = S_DONE;
        end else begin
          state_n = S_REQ_NXT;
        end
      end
      S_REQ_NXT: begin
        rd_req_o  = 1'b1;
        rd_addr_o = cur_ptr + 1'b1;
        state_n   = S_WAIT_NXT;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tgt_q   <= '0;
      raw_q   <= '0;
      off_q   <= '0;
      found_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      tgt_q   <= tgt_n;
      raw_q   <= raw_n;
      off_q   <= off_n;
      found_q <= found_n;
      err_q   <= err_n;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign found_o  = done_o & found_q;
  assign err_o    = done_o & err_q;
  assign offset_o = off_q;
endmodule

// File: rtl/cw_walker_chk.sv
module cw_walker_chk #(
  parameter int PTR_W      = 8,
  parameter int MAX_HOPS   = 48,
  parameter int ALIGN_BITS = 2,
  parameter logic [PTR_W-1:0] HDR_OFS  = 8'h34,
  parameter logic [PTR_W-1:0] CAP_BASE = 8'h40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rd_req_o,
  input logic [PTR_W-1:0] rd_addr_o,
  input logic             rd_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             found_o,
  input logic             err_o,
  input logic [PTR_W-1:0] offset_o
);
  localparam int RD_MAX = 2 * MAX_HOPS + 1;
  localparam int CW     = $clog2(RD_MAX + 2);

  logic          outst_q;
  logic [CW-1:0] rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outst_q <= 1'b0;
    else if (rd_req_o)   outst_q <= 1'b1;
    else if (rd_valid_i) outst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_cnt_q <= '0;
    else if (start_i && !busy_o) rd_cnt_q <= '0;
    else if (rd_req_o)           rd_cnt_q <= rd_cnt_q + 1'b1;
  end

  a_r2_first_read_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (rd_req_o && rd_addr_o == HDR_OFS));

  a_r3_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (offset_o[ALIGN_BITS-1:0] == '0 && offset_o >= CAP_BASE));

  a_r7_no_low_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_addr_o != HDR_OFS) |-> (rd_addr_o >= CAP_BASE));

  a_r8_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rd_cnt_q <= CW'(RD_MAX)));

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !outst_q);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r11_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o || err_o) |-> (done_o && !(found_o && err_o)));
endmodule

bind cap_walker cw_walker_chk #(
  .PTR_W(PTR_W), .MAX_HOPS(MAX_HOPS), .ALIGN_BITS(ALIGN_BITS),
  .HDR_OFS(HDR_OFS), .CAP_BASE(CAP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .busy_o(busy_o),
  .done_o(done_o), .found_o(found_o), .err_o(err_o), .offset_o(offset_o)
);

// File: tb/tb_cap_walker.sv
module tb_cap_walker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] target_id_i;
  logic       rd_req_o;
  logic [7:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic       rd_valid_i;
  logic       busy_o, done_o, found_o, err_o;
  logic [7:0] offset_o;

  cap_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_id_i(target_id_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .rd_valid_i(rd_valid_i), .busy_o(busy_o), .done_o(done_o),
    .found_o(found_o), .err_o(err_o), .offset_o(offset_o)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_q[$];
  logic exp_found, exp_err;
  logic [7:0] exp_off;
  bit done_seen, armed;
  int lat = 0;
  bit pend = 0;
  int wait_n = 0;
  logic [7:0] pend_addr;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // reference walk: expected read addresses and result
  task automatic model(input logic [7:0] tgt);
    logic [7:0] p;
    int hops = 0;
    exp_q.delete();
    exp_found = 0; exp_err = 0; exp_off = 8'h00;
    exp_q.push_back(8'h34);
    p = mem[8'h34] & 8'hFC;
    forever begin
      if (p == 0) return;
      if (p < 8'h40 || hops == 48) begin exp_err = 1; return; end
      hops++;
      exp_q.push_back(p);
      if (mem[p] == tgt) begin exp_found = 1; exp_off = p; return; end
      exp_q.push_back(p + 8'd1);
      p = mem[p + 8'd1] & 8'hFC;
    end
  endtask

  // per-clock monitor and memory responder
  initial begin
    rd_valid_i = 0; rd_data_i = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (armed) begin
        if (rd_req_o) begin
          if (exp_q.size() == 0) chk(0, "R4 unexpected read", rd_addr_o, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_addr_o == e, "R4/R3 read address", rd_addr_o, e);
          end
        end
        if (done_o) begin
          chk(found_o == exp_found, "R5/R6 found", found_o, exp_found);
          chk(err_o == exp_err, "R7/R8 err", err_o, exp_err);
          chk(offset_o == exp_off, "R5 offset", offset_o, exp_off);
          chk(exp_q.size() == 0, "R4 reads missing", exp_q.size(), 0);
          chk(busy_o == 1, "R11 busy in done cycle", busy_o, 1);
          done_seen = 1;
        end
      end
      if (!done_o && (found_o || err_o)) chk(0, "R11 flag without done", {found_o, err_o}, 0);
      rd_valid_i = 0;
      if (pend) begin
        if (wait_n == 0) begin
          rd_valid_i = 1; rd_data_i = mem[pend_addr]; pend = 0;
        end else wait_n--;
      end else if (rd_req_o) begin
        if (pend) chk(0, "R9 second outstanding", 1, 0);
        pend = 1; wait_n = lat; pend_addr = rd_addr_o;
      end
    end
  end

  initial begin
    while (cycles < 100000) @(posedge clk);
    chk(0, "watchdog", cycles, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run(input logic [7:0] tgt, input int l, input bit restart);
    lat = l;
    model(tgt);
    done_seen = 0; armed = 1;
    @(negedge clk);
    start_i = 1; target_id_i = tgt;
    @(negedge clk);
    start_i = 0; target_id_i = 8'h00;
    chk(busy_o == 1, "R2 busy after start", busy_o, 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      start_i = 1; target_id_i = ~tgt;   // R10: must be ignored
      @(negedge clk);
      start_i = 0;
    end
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R11 single done then idle", {done_o, busy_o}, 0);
    armed = 0;
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic std_list();
    clr_mem();
    mem[8'h34] = 8'h40;
    mem[8'h40] = 8'h01; mem[8'h41] = 8'h50;
    mem[8'h50] = 8'h05; mem[8'h51] = 8'h70;
    mem[8'h70] = 8'h10; mem[8'h71] = 8'h00;
  endtask

  initial begin
    rst_n = 0; start_i = 0; target_id_i = 0; armed = 0;
    clr_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0 && found_o == 0 && err_o == 0 && rd_req_o == 0,
        "R1 reset outputs", {busy_o, done_o, found_o, err_o, rd_req_o}, 0);
    chk(offset_o == 0, "R1 reset offset", offset_o, 0);
    rst_n = 1;
    @(negedge clk);

    std_list();
    run(8'h10, 0, 0);            // R5 last entry match
    run(8'h11, 0, 0);            // R6 end of list, not found
    run(8'h01, 3, 0);            // R9 long latency, first entry
    run(8'h05, 1, 1);            // R10 restart ignored mid-walk

    clr_mem();                   // R3 stray low bits
    mem[8'h34] = 8'h43;
    mem[8'h40] = 8'h09; mem[8'h41] = 8'h52;
    mem[8'h50] = 8'h05; mem[8'h51] = 8'h03;
    run(8'h05, 0, 0);
    run(8'h77, 2, 0);            // R3/R6: 03h masks to null

    clr_mem(); mem[8'h34] = 8'h20;   // R7 head pointer below region
    run(8'h01, 0, 0);
    std_list(); mem[8'h51] = 8'h3C;  // R7 link below region mid-chain
    run(8'h10, 0, 0);
    clr_mem();                       // R6 empty list: one read only
    run(8'h01, 0, 0);

    clr_mem(); mem[8'h34] = 8'h40;   // R8 circular list
    mem[8'h40] = 8'h09; mem[8'h41] = 8'h40;
    run(8'h10, 0, 0);

    clr_mem(); mem[8'h34] = 8'h40;   // R8 full chain of 48 entries
    for (int k = 0; k < 48; k++) begin
      mem[8'h40 + 4*k]     = 8'h20;
      mem[8'h40 + 4*k + 1] = (k == 47) ? 8'h00 : 8'(8'h44 + 4*k);
    end
    run(8'h99, 0, 0);
    mem[8'hFC] = 8'h11;
    run(8'h11, 1, 0);                // R5 match at FCh

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule